// File: doc/BRIEF.md
# Dual-Mode Serial Register Slave

This block lets an external master read and write a small register bank through one set of pads that is time-shared between a two-wire I2C slave and an SPI slave. The chip-select pad picks the bus: held high, the block answers as an I2C slave with a fixed 7-bit device address; pulled low, it takes an SPI frame. A configuration input chooses whether SPI read data leaves on a dedicated SDO pad (4-wire) or on the shared data pad (3-wire).

All three input pads pass through two-flop synchronisers, and every bus edge is found from the synchronised samples, so the block runs entirely in the system clock domain. The register bank sits outside. It sees one address, one write-data bus and a single-cycle write strobe, and it returns read data combinationally for the address presented.

I2C engine states: IDLE, ADDR (shift in the address byte), ADDR_ACK, RX, RX_ACK, TX, TX_ACK and SKIP. START goes from any state to ADDR, and STOP goes from any state to IDLE. From ADDR the engine moves to ADDR_ACK when the address matches and to SKIP when it does not. ADDR_ACK leads to TX for a read and to RX for a write. RX and RX_ACK alternate, and so do TX and TX_ACK. A NACK in TX_ACK leads to SKIP.

SPI engine states: IDLE, CMD (R/W bit and address), DATA and DONE. The engine moves from IDLE to CMD while chip-select is low, from CMD to DATA after the 8th rising edge, and from DATA to DONE after the 16th rising edge. It returns to IDLE whenever chip-select is high.

Top module: `serreg_slave`

## Requirements
- R1: A high level on `cs_pad` selects I2C operation and a low level selects SPI. Both modes use one register bank. While `cs_pad` is high, `sdo_pad_oe` is 0.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. STOP releases the data pad (`dat_pad_oe` = 0) and returns the engine to idle.
- R3: An address byte whose upper seven bits equal 7'b0011101 is acknowledged by pulling the data line low during the ninth clock. Any other address gets no acknowledge, no drive and no register write until the next START or STOP.
- R4: In an I2C write (direction bit 0), the first byte after the address sets the register index. Each later byte is written to the index, and the index then advances by one. Every byte is acknowledged.
- R5: In an I2C read (direction bit 1), bytes are sent MSB first from the current index, and the index advances after each byte. A master NACK ends sending and leaves the line released.
- R6: In I2C mode the pad is only ever driven low. Apart from START and STOP, the drive changes only while SCL is low.
- R7: An SPI frame starts when chip-select falls. Bit 0 is R/W (1 = read), then comes a 7-bit address MSB first, then 8 data bits MSB first, all sampled on rising SPC. A write is committed after the 16th rising edge.
- R8: In an SPI read, data is driven MSB first on falling SPC edges starting with the 9th. In 4-wire mode (`spi_3wire` = 0) it leaves on `sdo_pad_out` and the shared pad stays undriven.
- R9: In 3-wire mode (`spi_3wire` = 1), read data leaves on the shared data pad and `sdo_pad_oe` stays 0.
- R10: A data-pad drive change in response to an SCL edge appears after the third system clock rising edge following the pad edge.
- R11: `reg_we` is a single-cycle pulse, given once per written byte.
- R12: After reset no pad is driven and no write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_pad | input | 1 | Chip-select pad: 1 = I2C, 0 = SPI frame |
| sck_pad | input | 1 | Shared SCL / SPC clock pad |
| dat_pad_in | input | 1 | Shared data pad, input side |
| dat_pad_out | output | 1 | Shared data pad, output value (0 in I2C mode) |
| dat_pad_oe | output | 1 | Shared data pad output enable |
| sdo_pad_out | output | 1 | 4-wire SPI serial data out |
| sdo_pad_oe | output | 1 | SDO pad output enable |
| spi_3wire | input | 1 | Configuration bit: 1 = 3-wire SPI |
| reg_addr | output | 7 | Register bank address |
| reg_wdata | output | 8 | Register bank write data |
| reg_we | output | 1 | Register bank write strobe |
| reg_rdata | input | 8 | Register bank read data for `reg_addr` |

## Verification
Each result is due at the third system clock edge after the pad edge that causes it: two synchroniser stages, then the registered state and output. The bench drives pads on falling system clock edges, holds every SCL/SPC phase for ten system clocks, and samples the data line in the middle of the high phase, long after that three-cycle delay. The R10 check counts falling edges exactly, expecting no drive two edges after SCL falls and the acknowledge drive one edge later. Bank contents are read out after STOP or after chip-select rises, once the last write strobe has passed.

// File: rtl/serreg_pkg.sv
`timescale 1ns/1ps
package serreg_pkg;
    typedef enum logic [2:0] {
        I_IDLE, I_ADDR, I_ADDR_ACK, I_RX, I_RX_ACK, I_TX, I_TX_ACK, I_SKIP
    } i2c_st_e;

    typedef enum logic [1:0] {
        S_IDLE, S_CMD, S_DATA, S_DONE
    } spi_st_e;
endpackage

// File: rtl/serreg_pad_sync.sv
`timescale 1ns/1ps
module serreg_pad_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                stg[g] <= RST_VAL;
            else if (g == 0)
                stg[g] <= d;
            else
                stg[g] <= stg[(g == 0) ? 0 : g-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/serreg_i2c_engine.sv
`timescale 1ns/1ps
module serreg_i2c_engine
    import serreg_pkg::*;
#(
    parameter int         AW     = 7,
    parameter int         DW     = 8,
    parameter logic [6:0] DEV_ID = 7'b0011101
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          scl,
    input  logic          sda,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] idx,
    output logic [DW-1:0] wdata,
    output logic          we,
    output logic          sda_oe
);
    localparam int CW = $clog2(DW) + 1;

    i2c_st_e       st, nxt;
    logic          scl_q, sda_q;
    logic [CW-1:0] cnt;
    logic [DW-1:0] sh, tx;
    logic          rw, have_idx, nack;

    wire rise  = scl & ~scl_q;
    wire fall  = ~scl & scl_q;
    wire start = scl & scl_q & sda_q & ~sda;
    wire stop  = scl & scl_q & ~sda_q & sda;
    wire full  = (cnt == CW'(DW));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= I_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        if (!en || stop)
            nxt = I_IDLE;
        else if (start)
            nxt = I_ADDR;
        else begin
            unique case (st)
                I_IDLE:     nxt = I_IDLE;
                I_ADDR:     if (fall && full) nxt = (sh[7:1] == DEV_ID) ? I_ADDR_ACK : I_SKIP;
                I_ADDR_ACK: if (fall) nxt = rw ? I_TX : I_RX;
                I_RX:       if (fall && full) nxt = I_RX_ACK;
                I_RX_ACK:   if (fall) nxt = I_RX;
                I_TX:       if (fall && full) nxt = I_TX_ACK;
                I_TX_ACK:   if (fall) nxt = nack ? I_SKIP : I_TX;
                I_SKIP:     nxt = I_SKIP;
                default:    nxt = I_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;  sda_q <= 1'b1;
            cnt <= '0;  sh <= '0;  tx <= '0;
            rw <= 1'b0;  have_idx <= 1'b0;  nack <= 1'b0;
            idx <= '0;  wdata <= '0;  we <= 1'b0;  sda_oe <= 1'b0;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
            we    <= 1'b0;
            if (we) idx <= idx + 1'b1;
            if (!en || stop || start) begin
                sda_oe <= 1'b0;
                cnt    <= '0;
            end else begin
                unique case (st)
                    I_ADDR, I_RX: begin
                        if (rise) begin
                            sh  <= {sh[DW-2:0], sda};
                            cnt <= cnt + 1'b1;
                        end
                        if (fall && full) begin
                            cnt <= '0;
                            if (st == I_ADDR) begin
                                have_idx <= 1'b0;
                                rw       <= sh[0];
                                sda_oe   <= (sh[7:1] == DEV_ID);
                            end else begin
                                sda_oe <= 1'b1;
                                if (!have_idx) begin
                                    idx      <= sh[AW-1:0];
                                    have_idx <= 1'b1;
                                end else begin
                                    we    <= 1'b1;
                                    wdata <= sh;
                                end
                            end
                        end
                    end
                    I_ADDR_ACK, I_TX_ACK: begin
                        if (rise) nack <= sda;
                        if (fall) begin
                            cnt <= '0;
                            if ((st == I_ADDR_ACK && rw) || (st == I_TX_ACK && !nack)) begin
                                sda_oe <= ~rdata[DW-1];
                                tx     <= {rdata[DW-2:0], 1'b0};
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    I_RX_ACK: if (fall) sda_oe <= 1'b0;
                    I_TX: begin
                        if (rise) cnt <= cnt + 1'b1;
                        if (fall) begin
                            if (full) begin
                                sda_oe <= 1'b0;
                                idx    <= idx + 1'b1;
                                cnt    <= '0;
                            end else begin
                                sda_oe <= ~tx[DW-1];
                                tx     <= {tx[DW-2:0], 1'b0};
                            end
                        end
                    end
                    default: sda_oe <= 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/serreg_spi_engine.sv
`timescale 1ns/1ps
module serreg_spi_engine
    import serreg_pkg::*;
#(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          spc,
    input  logic          sdi,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata,
    output logic          we,
    output logic          out_bit,
    output logic          out_en
);
    localparam int FL = 1 + AW + DW;
    localparam int CW = $clog2(FL + 1);

    spi_st_e       st, nxt;
    logic          spc_q, rw, loaded;
    logic [CW-1:0] cnt;
    logic [DW-1:0] sh, tx;

    wire rise = spc & ~spc_q;
    wire fall = ~spc & spc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        if (!en)
            nxt = S_IDLE;
        else begin
            unique case (st)
                S_IDLE:  nxt = S_CMD;
                S_CMD:   if (rise && cnt == CW'(AW)) nxt = S_DATA;
                S_DATA:  if (rise && cnt == CW'(FL-1)) nxt = S_DONE;
                S_DONE:  nxt = S_DONE;
                default: nxt = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spc_q <= 1'b1;  rw <= 1'b0;  loaded <= 1'b0;
            cnt <= '0;  sh <= '0;  tx <= '0;
            addr <= '0;  wdata <= '0;  we <= 1'b0;
            out_bit <= 1'b0;  out_en <= 1'b0;
        end else begin
            spc_q <= spc;
            we    <= 1'b0;
            if (!en) begin
                cnt    <= '0;
                loaded <= 1'b0;
                out_en <= 1'b0;
            end else begin
                unique case (st)
                    S_CMD: if (rise) begin
                        cnt <= cnt + 1'b1;
                        if (cnt == '0) rw <= sdi;
                        else           addr <= {addr[AW-2:0], sdi};
                    end
                    S_DATA: begin
                        if (rise) begin
                            cnt <= cnt + 1'b1;
                            sh  <= {sh[DW-2:0], sdi};
                            if (cnt == CW'(FL-1) && !rw) begin
                                we    <= 1'b1;
                                wdata <= {sh[DW-2:0], sdi};
                            end
                        end
                        if (fall && rw) begin
                            out_en <= 1'b1;
                            if (!loaded) begin
                                loaded  <= 1'b1;
                                out_bit <= rdata[DW-1];
                                tx      <= {rdata[DW-2:0], 1'b0};
                            end else begin
                                out_bit <= tx[DW-1];
                                tx      <= {tx[DW-2:0], 1'b0};
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/serreg_slave.sv
`timescale 1ns/1ps
module serreg_slave #(
    parameter int         AW     = 7,
    parameter int         DW     = 8,
    parameter int         STAGES = 2,
    parameter logic [6:0] DEV_ID = 7'b0011101
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_pad,
    input  logic          sck_pad,
    input  logic          dat_pad_in,
    output logic          dat_pad_out,
    output logic          dat_pad_oe,
    output logic          sdo_pad_out,
    output logic          sdo_pad_oe,
    input  logic          spi_3wire,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          reg_we,
    input  logic [DW-1:0] reg_rdata
);
    logic          cs_s, scl_s, sda_s;
    logic [AW-1:0] i_idx, s_addr;
    logic [DW-1:0] i_wdata, s_wdata;
    logic          i_we, s_we, i_oe, s_bit, s_en;

    serreg_pad_sync #(.W(3), .STAGES(STAGES), .RST_VAL(3'b111)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({cs_pad, sck_pad, dat_pad_in}),
        .q({cs_s, scl_s, sda_s})
    );

    serreg_i2c_engine #(.AW(AW), .DW(DW), .DEV_ID(DEV_ID)) u_i2c (
        .clk(clk), .rst_n(rst_n), .en(cs_s), .scl(scl_s), .sda(sda_s),
        .rdata(reg_rdata), .idx(i_idx), .wdata(i_wdata), .we(i_we), .sda_oe(i_oe)
    );

    serreg_spi_engine #(.AW(AW), .DW(DW)) u_spi (
        .clk(clk), .rst_n(rst_n), .en(~cs_s), .spc(scl_s), .sdi(sda_s),
        .rdata(reg_rdata), .addr(s_addr), .wdata(s_wdata), .we(s_we),
        .out_bit(s_bit), .out_en(s_en)
    );

    assign reg_addr    = cs_s ? i_idx : s_addr;
    assign reg_wdata   = cs_s ? i_wdata : s_wdata;
    assign reg_we      = i_we | s_we;
    assign dat_pad_oe  = cs_s ? i_oe : (s_en & spi_3wire);
    assign dat_pad_out = cs_s ? 1'b0 : s_bit;
    assign sdo_pad_oe  = ~cs_s & s_en & ~spi_3wire;
    assign sdo_pad_out = s_bit;
endmodule

module serreg_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_pad,
    input logic cs_s,
    input logic scl_s,
    input logic sda_s,
    input logic dat_oe,
    input logic sdo_oe,
    input logic reg_we
);
    logic scl_q, sda_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end
    wire start_c = cs_s & scl_s & scl_q & sda_q & ~sda_s;
    wire stop_c  = cs_s & scl_s & scl_q & ~sda_q & sda_s;

    p_sdo_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_pad, 2) |-> !sdo_oe);

    p_stop_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_c |=> !dat_oe);

    p_sda_change_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && $past(cs_s) && !$past(start_c) && !$past(stop_c) && (dat_oe != $past(dat_oe)))
        |-> !$past(scl_s));

    p_we_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);
endmodule

bind serreg_slave serreg_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_pad(cs_pad), .cs_s(cs_s), .scl_s(scl_s),
    .sda_s(sda_s), .dat_oe(dat_pad_oe), .sdo_oe(sdo_pad_oe), .reg_we(reg_we)
);

// File: tb/sim_serreg_slave.sv
`timescale 1ns/1ps
module sim_serreg_slave;
    localparam int H = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_pad = 1'b1, sck = 1'b1, m_sda = 1'b1, three = 1'b0;
    logic       dat_out, dat_oe, sdo_out, sdo_oe, reg_we;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [7:0] mem [128];
    wire        line = cs_pad ? (m_sda & ~(dat_oe & ~dat_out)) : (dat_oe ? dat_out : m_sda);
    wire        sdo_line = sdo_oe ? sdo_out : 1'b1;

    int  n_chk = 0, n_fail = 0, we_cnt = 0;
    bit  done = 1'b0, seen_dat = 1'b0, seen_sdo = 1'b0;

    always #2.5 clk = ~clk;

    serreg_slave u0 (
        .clk(clk), .rst_n(rst_n), .cs_pad(cs_pad), .sck_pad(sck), .dat_pad_in(line),
        .dat_pad_out(dat_out), .dat_pad_oe(dat_oe), .sdo_pad_out(sdo_out),
        .sdo_pad_oe(sdo_oe), .spi_3wire(three), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
    );

    assign reg_rdata = mem[reg_addr];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) mem[i] <= 8'h00;
        end else if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
            we_cnt <= we_cnt + 1;
        end
    end
    always @(negedge clk) begin
        if (!cs_pad && !three && dat_oe) seen_dat <= 1'b1;
        if (!cs_pad && three && sdo_oe) seen_sdo <= 1'b1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start;
        m_sda = 1'b1; hw(H); sck = 1'b1; hw(H); m_sda = 1'b0; hw(H); sck = 1'b0; hw(H);
    endtask

    task automatic i2c_stop;
        m_sda = 1'b0; hw(H); sck = 1'b1; hw(H); m_sda = 1'b1; hw(H);
    endtask

    task automatic i2c_wbyte(input logic [7:0] b, input bit lat, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; hw(H); sck = 1'b1; hw(H); sck = 1'b0;
        end
        if (lat) begin
            hw(2); chk(dat_oe == 1'b0, "R10 early", dat_oe, 0);
            hw(1); chk(dat_oe == 1'b1, "R10 due", dat_oe, 1);
            m_sda = 1'b1; hw(H - 3);
        end else begin
            hw(1); m_sda = 1'b1; hw(H - 1);
        end
        sck = 1'b1; hw(H / 2); ack = ~line; hw(H / 2); sck = 1'b0; hw(1);
    endtask

    task automatic i2c_rbyte(input bit nack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hw(H); sck = 1'b1; hw(H / 2); b[i] = line; hw(H / 2); sck = 1'b0;
        end
        hw(1); m_sda = nack; hw(H - 1); sck = 1'b1; hw(H); sck = 1'b0; hw(1); m_sda = 1'b1;
    endtask

    task automatic spi_xfer(input bit rd, input logic [6:0] a, input logic [7:0] wd,
                            output logic [7:0] rv);
        logic [15:0] bits;
        bits = {rd, a, wd};
        rv = 8'h00;
        cs_pad = 1'b0; hw(H);
        for (int i = 0; i < 16; i++) begin
            sck = 1'b0;
            m_sda = (rd && i >= 8) ? 1'b1 : bits[15-i];
            hw(H); sck = 1'b1;
            if (i >= 8) rv[15-i] = three ? line : sdo_line;
            hw(H);
        end
        m_sda = 1'b1; hw(H); cs_pad = 1'b1; hw(2 * H);
    endtask

    task automatic t_reset;
        chk(dat_oe == 1'b0, "R12 dat_oe", dat_oe, 0);
        chk(sdo_oe == 1'b0, "R12 sdo_oe", sdo_oe, 0);
        chk(we_cnt == 0, "R12 no write", we_cnt, 0);
    endtask

    task automatic t_i2c_write;
        bit a;
        int w0;
        w0 = we_cnt;
        i2c_start;
        i2c_wbyte(8'h3A, 1'b1, a); chk(a, "R3 address ack", a, 1);
        i2c_wbyte(8'h10, 1'b0, a); chk(a, "R4 index ack", a, 1);
        i2c_wbyte(8'h11, 1'b0, a); chk(a, "R4 data ack", a, 1);
        i2c_wbyte(8'h22, 1'b0, a);
        i2c_wbyte(8'h33, 1'b0, a); chk(a, "R4 last ack", a, 1);
        i2c_stop; hw(4);
        chk(dat_oe == 1'b0, "R2 released after stop", dat_oe, 0);
        chk(mem[16] == 8'h11, "R4 reg 0x10", mem[16], 8'h11);
        chk(mem[17] == 8'h22, "R4 reg 0x11", mem[17], 8'h22);
        chk(mem[18] == 8'h33, "R4 reg 0x12", mem[18], 8'h33);
        chk(we_cnt - w0 == 3, "R11 one strobe per byte", we_cnt - w0, 3);
    endtask

    task automatic t_i2c_read;
        bit a;
        logic [7:0] b;
        int w0;
        w0 = we_cnt;
        i2c_start;
        i2c_wbyte(8'h3A, 1'b0, a);
        i2c_wbyte(8'h11, 1'b0, a);
        i2c_start;
        i2c_wbyte(8'h3B, 1'b0, a); chk(a, "R3 read address ack", a, 1);
        i2c_rbyte(1'b0, b); chk(b == 8'h22, "R5 first byte", b, 8'h22);
        i2c_rbyte(1'b1, b); chk(b == 8'h33, "R5 incremented byte", b, 8'h33);
        hw(4); chk(dat_oe == 1'b0, "R5 released after nack", dat_oe, 0);
        i2c_stop; hw(4);
        chk(dat_oe == 1'b0, "R2 idle after stop", dat_oe, 0);
        chk(we_cnt == w0, "R5 read writes nothing", we_cnt - w0, 0);
    endtask

    task automatic t_i2c_wrong;
        bit a;
        logic [7:0] b;
        int w0;
        w0 = we_cnt;
        i2c_start;
        i2c_wbyte(8'h3C, 1'b0, a); chk(!a, "R3 foreign address no ack", a, 0);
        i2c_wbyte(8'h10, 1'b0, a); chk(!a, "R3 no ack after foreign", a, 0);
        i2c_wbyte(8'h99, 1'b0, a);
        i2c_stop; hw(4);
        chk(mem[16] == 8'h11, "R3 bank untouched", mem[16], 8'h11);
        chk(we_cnt == w0, "R3 no write", we_cnt - w0, 0);
        i2c_start;
        i2c_wbyte(8'h5B, 1'b0, a);
        i2c_rbyte(1'b1, b); chk(b == 8'hFF, "R3 line not driven on foreign read", b, 8'hFF);
        i2c_stop;
    endtask

    task automatic t_spi4;
        logic [7:0] r;
        three = 1'b0; seen_dat = 1'b0;
        spi_xfer(1'b0, 7'h22, 8'hA5, r); hw(2);
        chk(mem[34] == 8'hA5, "R7 spi write", mem[34], 8'hA5);
        spi_xfer(1'b1, 7'h22, 8'h00, r);
        chk(r == 8'hA5, "R8 spi 4-wire read", r, 8'hA5);
        spi_xfer(1'b1, 7'h12, 8'h00, r);
        chk(r == 8'h33, "R8 spi read other reg", r, 8'h33);
        chk(!seen_dat, "R8 shared pad undriven", seen_dat, 0);
        chk(sdo_oe == 1'b0, "R1 sdo off with cs high", sdo_oe, 0);
    endtask

    task automatic t_spi3;
        logic [7:0] r;
        three = 1'b1; seen_sdo = 1'b0;
        spi_xfer(1'b0, 7'h5A, 8'h3C, r); hw(2);
        chk(mem[90] == 8'h3C, "R7 3-wire write", mem[90], 8'h3C);
        spi_xfer(1'b1, 7'h10, 8'h00, r);
        chk(r == 8'h11, "R9 3-wire read", r, 8'h11);
        chk(!seen_sdo, "R9 sdo pad off", seen_sdo, 0);
        three = 1'b0;
    endtask

    task automatic t_cross;
        bit a;
        logic [7:0] b;
        i2c_start;
        i2c_wbyte(8'h3A, 1'b0, a);
        i2c_wbyte(8'h22, 1'b0, a);
        i2c_start;
        i2c_wbyte(8'h3B, 1'b0, a);
        i2c_rbyte(1'b1, b); chk(b == 8'hA5, "R1 shared bank via I2C", b, 8'hA5);
        i2c_stop;
    endtask

    initial begin
        hw(5); rst_n = 1'b1; hw(5);
        t_reset;
        t_i2c_write;
        t_i2c_read;
        t_i2c_wrong;
        t_spi4;
        t_spi3;
        t_cross;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule